// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block sits between an access controller and a low-power pseudo-SRAM that needs a long settling interval after power is applied and after it leaves its deep power down mode. It drives the memory's deep-power-down control pin (CS2, active low for power down) and qualifies the controller's chip-select. Out of reset it holds the memory deselected for the settling interval. After that it raises a ready flag that tells the controller it may issue cycles.

A one-cycle sleep request drives CS2 low and the memory loses its contents. A wake request drives CS2 high again and starts a fresh settling interval. A sticky data-lost flag is set whenever power down is entered, so the controller knows it must reinitialise the array. The controller clears the flag with an acknowledge. While the block is not ready, the controller's chip-select is forced inactive, so requests are held off rather than dropped. A sleep request that arrives during a settling interval is remembered and carried out when that interval ends.

The settling length is computed from the clock rate in kHz and the wait in microseconds, rounded up to whole cycles, plus a margin of extra cycles.

Top module: `psram_pwr_seq`

## Requirements
- R1: During and just after reset, `memCs2` is 1, `ready` is 0, `dataLost` is 0 and `memCs1n` is 1.
- R2: `ready` rises exactly W = ceil(CLK_KHZ*WAIT_US/1000)+MARGIN clock edges after reset is released, and stays 0 before that.
- R3: When `ready` is 1 and `sleepReq` is 1 at an edge, after that edge `memCs2` is 0 and `ready` is 0.
- R4: While `memCs2` is 0, it stays 0 until an edge that sees `wakeReq` = 1. `sleepReq` has no effect in that state.
- R5: An edge that sees `wakeReq` = 1 while `memCs2` is 0 sets `memCs2` to 1 with `ready` 0. `ready` then rises exactly W edges after that edge.
- R6: `dataLost` becomes 1 on every entry to power down. It stays 1 until an edge that sees `lostAck` = 1 with no entry at that same edge. When the two coincide, the entry wins.
- R7: `memCs1n` equals `accCs1n` while `ready` is 1 and is 1 otherwise.
- R8: A `sleepReq` pulse that arrives during a settling interval is held. At the end of that interval the block goes straight to power down (`memCs2` 0, `dataLost` 1) without raising `ready`.
- R9: `wakeReq` has no effect while `memCs2` is 1. `lostAck` has no effect on the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Request to enter deep power down |
| wakeReq | input | 1 | Request to leave deep power down |
| lostAck | input | 1 | Clears the data-lost flag |
| accCs1n | input | 1 | Chip-select from the access controller, active low |
| memCs1n | output | 1 | Qualified chip-select to the memory, active low |
| memCs2 | output | 1 | Deep power down control to the memory, low = power down |
| ready | output | 1 | Memory may be accessed |
| dataLost | output | 1 | Array contents lost since the last acknowledge |

## Verification
The bench builds the block with CLK_KHZ=33, WAIT_US=200 and MARGIN=1. The exact product of 6.6 cycles is rounded up to 7, and the margin makes W = 8. This keeps the rounding and the margin observable while every settling interval stays short. With a wait this short, the bench can walk power-up, several sleep/wake round trips and a sleep request held inside an interval. It checks the rise of `ready` at edge W-1 and at edge W each time.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_READY  = 2'd1,
    ST_DEEP   = 2'd2
  } pwrState_e;

  typedef struct packed {
    logic cntRun;   // settling counter advances
    logic setLost;  // entering power down this edge
  } seqStrobe_t;

  function automatic int unsigned settleCycles(input int unsigned khz,
                                               input int unsigned us,
                                               input int unsigned margin);
    return (khz * us + 999) / 1000 + margin;
  endfunction

endpackage

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       waitDone,
  output seqStrobe_t strobe,
  output logic       cs2Out,
  output logic       readyOut
);

  pwrState_e state, stateNext;
  logic      sleepPend, sleepPendNext;
  logic      takeSleep;

  always_comb begin
    stateNext     = state;
    sleepPendNext = 1'b0;
    takeSleep     = sleepPend | sleepReq;
    strobe        = '0;
    unique case (state)
      ST_SETTLE: begin
        strobe.cntRun = 1'b1;
        sleepPendNext = takeSleep;
        if (waitDone) begin
          sleepPendNext = 1'b0;
          if (takeSleep) begin
            stateNext      = ST_DEEP;
            strobe.setLost = 1'b1;
          end else begin
            stateNext = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (sleepReq) begin
          stateNext      = ST_DEEP;
          strobe.setLost = 1'b1;
        end
      end
      ST_DEEP: begin
        if (wakeReq) stateNext = ST_SETTLE;
      end
      default: stateNext = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      sleepPend <= 1'b0;
    end else begin
      state     <= stateNext;
      sleepPend <= sleepPendNext;
    end
  end

  assign cs2Out   = (state != ST_DEEP);
  assign readyOut = (state == ST_READY);

endmodule

// File: rtl/psram_pwr_dp.sv
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       lostAck,
  input  logic       accCs1n,
  input  logic       readyIn,
  output logic       waitDone,
  output logic       lostOut,
  output logic       memCs1n
);

  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!strobe.cntRun || waitDone) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign waitDone = strobe.cntRun && (cnt == LAST_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostOut <= 1'b0;
    end else if (strobe.setLost) begin
      lostOut <= 1'b1;
    end else if (lostAck) begin
      lostOut <= 1'b0;
    end
  end

  assign memCs1n = readyIn ? accCs1n : 1'b1;

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned WAIT_US = 200,
  parameter int unsigned MARGIN  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic lostAck,
  input  logic accCs1n,
  output logic memCs1n,
  output logic memCs2,
  output logic ready,
  output logic dataLost
);

  localparam int unsigned WAIT_CYC = settleCycles(CLK_KHZ, WAIT_US, MARGIN);

  seqStrobe_t strobe;
  logic       waitDone;

  psram_pwr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .waitDone (waitDone),
    .strobe   (strobe),
    .cs2Out   (memCs2),
    .readyOut (ready)
  );

  psram_pwr_dp #(.WAIT_CYC(WAIT_CYC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lostAck  (lostAck),
    .accCs1n  (accCs1n),
    .readyIn  (ready),
    .waitDone (waitDone),
    .lostOut  (dataLost),
    .memCs1n  (memCs1n)
  );

endmodule

// File: rtl/psram_pwr_chk.sv
module psram_pwr_chk
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned WAIT_US = 200,
  parameter int unsigned MARGIN  = 1
) (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic wakeReq,
  input logic lostAck,
  input logic memCs1n,
  input logic memCs2,
  input logic ready,
  input logic dataLost
);

  localparam int unsigned WAIT_CYC = settleCycles(CLK_KHZ, WAIT_US, MARGIN);

  int unsigned highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= 0;
    else if (!memCs2) highCnt <= 0;
    else if (highCnt < WAIT_CYC) highCnt <= highCnt + 1;
  end

  p_settle_r2: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (highCnt >= WAIT_CYC));

  p_sleep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && sleepReq) |=> (!memCs2 && !ready));

  p_deep_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCs2 && !wakeReq) |=> !memCs2);

  p_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCs2 && wakeReq) |=> (memCs2 && !ready));

  p_lost_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCs2) |-> dataLost);

  p_lost_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataLost && !lostAck) |=> dataLost);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> memCs1n);

endmodule

bind psram_pwr_seq psram_pwr_chk #(
  .CLK_KHZ (CLK_KHZ),
  .WAIT_US (WAIT_US),
  .MARGIN  (MARGIN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sleepReq (sleepReq),
  .wakeReq  (wakeReq),
  .lostAck  (lostAck),
  .memCs1n  (memCs1n),
  .memCs2   (memCs2),
  .ready    (ready),
  .dataLost (dataLost)
);

// File: tb/psram_pwr_seq_test.sv
module psram_pwr_seq_test;

  localparam int unsigned KHZ = 33;
  localparam int unsigned US  = 200;
  localparam int unsigned MRG = 1;
  // 33 kHz * 200 us = 6.6 cycles -> 7, plus margin 1
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0, wakeReq = 1'b0, lostAck = 1'b0, accCs1n = 1'b1;
  logic memCs1n, memCs2, ready, dataLost;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  psram_pwr_seq #(.CLK_KHZ(KHZ), .WAIT_US(US), .MARGIN(MRG)) uut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .lostAck(lostAck), .accCs1n(accCs1n), .memCs1n(memCs1n),
    .memCs2(memCs2), .ready(ready), .dataLost(dataLost)
  );

  // {sleep, wake, ack, acc, expCs2, expReady, expLost, expCs1n}
  localparam logic [7:0] VEC [9] = '{
    8'b0000_1100,  // R7 passthrough low
    8'b0001_1101,  // R7 passthrough high
    8'b0100_1100,  // R9 wake ignored in ready
    8'b0010_1100,  // R9 ack with nothing lost
    8'b1000_0011,  // R3 enter power down, R6 lost set
    8'b1000_0011,  // R4 sleep ignored in power down
    8'b0010_0001,  // R6 ack clears
    8'b0000_0001,  // R4 stays down
    8'b0100_1001   // R5 wake, settling
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic a, input logic c);
    sleepReq = s; wakeReq = w; lostAck = a; accCs1n = c;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    accCs1n = 1'b0;
    step(2);
    chk("R1", "memCs2", memCs2, 1'b1);
    chk("R1", "ready", ready, 1'b0);
    chk("R1", "dataLost", dataLost, 1'b0);
    chk("R1", "memCs1n", memCs1n, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;          // edge 1 after release
    step(W - 2);
    chk("R2", "ready at W-1", ready, 1'b0);
    chk("R7", "memCs1n gated", memCs1n, 1'b1);
    step(1);
    chk("R2", "ready at W", ready, 1'b1);

    for (int v = 0; v < 9; v++) begin
      drive(VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      step(1);
      chk("R3/R4/R5/R6/R7/R9 vec", "memCs2", memCs2, VEC[v][3]);
      chk("R3/R4/R5/R6/R7/R9 vec", "ready", ready, VEC[v][2]);
      chk("R3/R4/R5/R6/R7/R9 vec", "dataLost", dataLost, VEC[v][1]);
      chk("R3/R4/R5/R6/R7/R9 vec", "memCs1n", memCs1n, VEC[v][0]);
    end
    drive(0, 0, 0, 0);
    step(W - 1);
    chk("R5", "ready W-1 after wake", ready, 1'b0);
    step(1);
    chk("R5", "ready W after wake", ready, 1'b1);
    chk("R7", "memCs1n follows", memCs1n, 1'b0);

    // R6: entry and acknowledge at the same edge
    drive(1, 0, 1, 0);
    step(1);
    chk("R6", "entry beats ack", dataLost, 1'b1);
    chk("R3", "memCs2 low", memCs2, 1'b0);
    drive(0, 0, 1, 0);
    step(1);
    chk("R6", "ack clears", dataLost, 1'b0);

    // R8: sleep pulse held during settling
    drive(0, 1, 0, 0);
    step(1);
    chk("R5", "wake raises cs2", memCs2, 1'b1);
    drive(0, 0, 0, 0);
    step(1);
    drive(1, 0, 0, 0);
    step(1);
    drive(0, 0, 0, 0);
    step(W - 3);
    chk("R8", "still settling cs2", memCs2, 1'b1);
    chk("R8", "no ready yet", ready, 1'b0);
    step(1);
    chk("R8", "pending sleep taken", memCs2, 1'b0);
    chk("R8", "ready never raised", ready, 1'b0);
    chk("R8", "lost set", dataLost, 1'b1);

    // R9: wake while settling is ignored, ready still on time
    drive(0, 1, 1, 0);
    step(1);
    drive(0, 1, 0, 0);
    step(W - 1);
    chk("R9", "wake in settle no early ready", ready, 1'b0);
    drive(0, 0, 0, 0);
    step(1);
    chk("R9", "ready on time", ready, 1'b1);
    chk("R9", "cs2 high", memCs2, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule